// File: doc/BRIEF.md
# Serial Packet Transmit Framer

This block turns a payload held in a small byte buffer into a complete serial frame. A frame is an alternating-pattern preamble, then an address field of one to four 16-bit words, then the payload bytes, then a 16-bit check value. The frame leaves the block on a single data line, one bit for each pulse of a symbol-enable strobe. The strobe comes from a fixed-rate symbol timer, so the bit rate does not depend on the system clock.

The host first writes the payload bytes into the buffer through a simple byte-write port. It then sets the preamble length, the address length, the address value, the payload length and the whitening switch, and pulses start. The block captures the whole configuration when the frame begins. It raises busy while the frame is in flight. It pulses done once, after the strobe that consumes the last check bit. When whitening is on, the payload and check bits are scrambled with a short pseudo-random sequence. The check value is always computed over the unscrambled bits.

Top module: `pkt_tx_framer`

## Requirements
- R1: After reset, busy, done and tx_bit are all 0.
- R2: A start pulse while idle captures the configuration and raises busy on the next clock edge. The frame then begins with (pre_len+1) bytes of 0xAA, each sent MSB first, so the first bit is 1.
- R3: After the preamble, the block sends bits addr_cfg[16*(addr_words+1)-1] down to addr_cfg[0], in that order (addr_words 0..3 selects 1..4 words).
- R4: After the address, the block sends pay_len bytes from buffer locations 0 up to pay_len-1, each MSB first. When pay_len is 0 the payload is skipped. pay_len must not exceed 64.
- R5: The last field is a 16-bit check value, sent MSB first. It is seeded with 0xFFFF and computed over the address and payload bits before whitening, one bit at a time: fb = crc[15] xor bit, crc = (crc << 1) xor (fb ? 0x1021 : 0).
- R6: When whiten_en is 1, each payload and check bit is XORed with w[6] of a 7-bit register w. The register w is set to 0x7F when the address field ends, and after each such bit it becomes {w[5:0], w[6] xor w[3]}. When whiten_en is 0, those bits go out unchanged.
- R7: A pulse on sym_en advances the frame by exactly one bit. Without sym_en, tx_bit and the frame position hold.
- R8: A start pulse while busy has no effect on the frame in flight.
- R9: The strobe that consumes the last check bit drops busy on the next edge and raises done for exactly one cycle. While idle, tx_bit is 0.
- R10: Changes to pre_len, addr_words, addr_cfg, pay_len or whiten_en during a frame have no effect on that frame.
- R11: While wr_en is 1, each clock edge stores wr_data at buffer location wr_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Buffer byte write enable |
| wr_addr | input | 6 | Buffer write location |
| wr_data | input | 8 | Buffer write byte |
| pay_len | input | 7 | Payload length in bytes, 0..64 |
| pre_len | input | 3 | Preamble bytes minus one |
| addr_words | input | 2 | Address words minus one |
| addr_cfg | input | 64 | Address value; the low 16*(addr_words+1) bits are used |
| whiten_en | input | 1 | Enable payload/check whitening |
| start | input | 1 | Begin a frame when idle |
| sym_en | input | 1 | Symbol strobe; one bit per pulse |
| tx_bit | output | 1 | Serial frame data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
On every cycle the assertions check the following. The frame position holds between strobes. A frame always opens with a 1 bit. Done appears only when busy falls and never while busy. The preamble is followed only by the address field. The captured configuration stays frozen while a frame runs. Only the bench scenarios can show that the bit stream itself is right: the preamble pattern and length, the address word selection, the payload byte order, the check value, and the whitening sequence. The bench compares every bit of a frame against a model built from the requirements. It sweeps all preamble and address lengths, several payload lengths and both whitening settings, and it disturbs the inputs during each frame.

// File: rtl/pktx_pkg.sv
package pktx_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_PRE  = 3'd1,
        PH_ADDR = 3'd2,
        PH_PAY  = 3'd3,
        PH_CRC  = 3'd4
    } phase_e;

    localparam logic [7:0]  PRE_BYTE   = 8'hAA;
    localparam logic [15:0] CRC_POLY   = 16'h1021;
    localparam logic [15:0] CRC_SEED   = 16'hFFFF;
    localparam logic [6:0]  WHITE_SEED = 7'h7F;
    localparam int          CRC_W      = 16;
endpackage

// File: rtl/pktx_buf.sv
module pktx_buf #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/pktx_crc_step.sv
module pktx_crc_step
    import pktx_pkg::*;
(
    input  logic [CRC_W-1:0] crc_in,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_out
);
    logic fb;
    always_comb begin
        fb      = crc_in[CRC_W-1] ^ bit_in;
        crc_out = {crc_in[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
endmodule

// File: rtl/pktx_whiten_step.sv
module pktx_whiten_step (
    input  logic [6:0] lfsr_in,
    output logic [6:0] lfsr_out
);
    always_comb lfsr_out = {lfsr_in[5:0], lfsr_in[6] ^ lfsr_in[3]};
endmodule

// File: rtl/pkt_tx_framer.sv
module pkt_tx_framer
    import pktx_pkg::*;
#(
    parameter int BUF_DEPTH = 64,
    parameter int PRE_MAX   = 8,
    parameter int ADDR_WMAX = 4,
    parameter int WORD_W    = 16,
    localparam int BUF_AW    = $clog2(BUF_DEPTH),
    localparam int LEN_W     = $clog2(BUF_DEPTH + 1),
    localparam int PRE_SEL   = $clog2(PRE_MAX),
    localparam int AW_SEL    = $clog2(ADDR_WMAX),
    localparam int ADDR_BITS = WORD_W * ADDR_WMAX
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [BUF_AW-1:0]    wr_addr,
    input  logic [7:0]           wr_data,
    input  logic [LEN_W-1:0]     pay_len,
    input  logic [PRE_SEL-1:0]   pre_len,
    input  logic [AW_SEL-1:0]    addr_words,
    input  logic [ADDR_BITS-1:0] addr_cfg,
    input  logic                 whiten_en,
    input  logic                 start,
    input  logic                 sym_en,
    output logic                 tx_bit,
    output logic                 busy,
    output logic                 done
);
    localparam int CNT_W  = BUF_AW + 3;
    localparam int AIDX_W = $clog2(ADDR_BITS);

    typedef struct packed {
        phase_e               phase;
        logic [CNT_W-1:0]     cnt;
        logic [CRC_W-1:0]     crc;
        logic [6:0]           lfsr;
        logic                 done;
        logic [PRE_SEL-1:0]   pre;
        logic [AW_SEL-1:0]    aw;
        logic [LEN_W-1:0]     len;
        logic                 wh;
        logic [ADDR_BITS-1:0] addr;
    } state_t;

    state_t st_d, st_q;

    logic [BUF_AW-1:0] rd_addr;
    logic [7:0]        rd_data;
    logic [AIDX_W-1:0] aidx;
    logic [31:0]       addr_last;
    logic              raw_bit, out_bit, mask;
    logic [CRC_W-1:0]  crc_nx;
    logic [6:0]        lfsr_nx;

    pktx_buf #(.DEPTH(BUF_DEPTH), .AW(BUF_AW)) u_buf (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    pktx_crc_step u_crc (.crc_in(st_q.crc), .bit_in(raw_bit), .crc_out(crc_nx));

    pktx_whiten_step u_wh (.lfsr_in(st_q.lfsr), .lfsr_out(lfsr_nx));

    assign rd_addr   = st_q.cnt[CNT_W-1:3];
    assign addr_last = (32'(st_q.aw) + 32'd1) * WORD_W - 32'd1;
    assign aidx      = AIDX_W'(addr_last - 32'(st_q.cnt));
    assign mask      = st_q.wh & st_q.lfsr[6];

    // bit selection for the current phase, before and after whitening
    always_comb begin
        raw_bit = 1'b0;
        out_bit = 1'b0;
        unique case (st_q.phase)
            PH_PRE:  begin raw_bit = PRE_BYTE[~st_q.cnt[2:0]]; out_bit = raw_bit; end
            PH_ADDR: begin raw_bit = st_q.addr[aidx];          out_bit = raw_bit; end
            PH_PAY:  begin raw_bit = rd_data[~st_q.cnt[2:0]];  out_bit = raw_bit ^ mask; end
            PH_CRC:  begin raw_bit = st_q.crc[CRC_W-1];        out_bit = raw_bit ^ mask; end
            default: ;
        endcase
    end

    always_comb begin
        logic        last;
        logic [31:0] last_idx;
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_PRE:  last_idx = 32'(st_q.pre) * 32'd8 + 32'd7;
            PH_ADDR: last_idx = addr_last;
            PH_PAY:  last_idx = 32'(st_q.len) * 32'd8 - 32'd1;
            default: last_idx = 32'(CRC_W - 1);
        endcase
        last = (32'(st_q.cnt) == last_idx);

        if (st_q.phase == PH_IDLE) begin
            if (start) begin
                st_d.phase = PH_PRE;
                st_d.cnt   = '0;
                st_d.crc   = CRC_SEED;
                st_d.pre   = pre_len;
                st_d.aw    = addr_words;
                st_d.len   = pay_len;
                st_d.wh    = whiten_en;
                st_d.addr  = addr_cfg;
            end
        end else if (sym_en) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
            unique case (st_q.phase)
                PH_ADDR: st_d.crc = crc_nx;
                PH_PAY:  begin st_d.crc = crc_nx; st_d.lfsr = lfsr_nx; end
                PH_CRC:  begin st_d.crc = {st_q.crc[CRC_W-2:0], 1'b0}; st_d.lfsr = lfsr_nx; end
                default: ;
            endcase
            if (last) begin
                st_d.cnt = '0;
                unique case (st_q.phase)
                    PH_PRE:  st_d.phase = PH_ADDR;
                    PH_ADDR: begin
                        st_d.phase = (st_q.len != '0) ? PH_PAY : PH_CRC;
                        st_d.lfsr  = WHITE_SEED;
                    end
                    PH_PAY:  st_d.phase = PH_CRC;
                    default: begin st_d.phase = PH_IDLE; st_d.done = 1'b1; end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = (st_q.phase != PH_IDLE);
    assign done   = st_q.done;
    assign tx_bit = busy & out_bit;

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !sym_en |=> $stable(st_q.cnt) && $stable(st_q.phase));
    // R2
    first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> tx_bit);
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R9
    done_fell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R3
    order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase == PH_PRE |=> st_q.phase == PH_PRE || st_q.phase == PH_ADDR);
    // R10
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(st_q.addr) && $stable(st_q.len) && $stable(st_q.wh)
                 && $stable(st_q.pre) && $stable(st_q.aw));
endmodule

// File: tb/pkt_tx_framer_test.sv
module pkt_tx_framer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [6:0]  pay_len = '0;
    logic [2:0]  pre_len = '0;
    logic [1:0]  addr_words = '0;
    logic [63:0] addr_cfg = '0;
    logic        whiten_en = 1'b0;
    logic        start = 1'b0;
    logic        sym_en = 1'b0;
    logic        tx_bit, busy, done;

    int checks = 0;
    int errors = 0;
    logic [7:0] ref_mem [64];
    logic       exp_bits [1024];
    int         n_exp;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_tx_framer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pay_len(pay_len), .pre_len(pre_len), .addr_words(addr_words), .addr_cfg(addr_cfg),
        .whiten_en(whiten_en), .start(start), .sym_en(sym_en),
        .tx_bit(tx_bit), .busy(busy), .done(done)
    );

    task automatic chk(input logic ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic fill(input int seed);
        for (int a = 0; a < 64; a++) begin
            @(negedge clk);
            wr_en   = 1'b1;
            wr_addr = 6'(a);
            wr_data = 8'(a * 37 + seed * 11 + 5);
            ref_mem[a] = wr_data;
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic push(input logic b);
        exp_bits[n_exp] = b;
        n_exp++;
    endtask

    // frame model built from R2..R6
    task automatic build(input int pre, input int aw, input int len, input logic wh, input logic [63:0] adr);
        logic [15:0] crc;
        logic [6:0]  w;
        logic        fb, b;
        n_exp = 0;
        crc = 16'hFFFF;
        for (int p = 0; p <= pre; p++)
            for (int k = 7; k >= 0; k--) push(k % 2 == 1);
        for (int i = 16 * (aw + 1) - 1; i >= 0; i--) begin
            b = adr[i];
            push(b);
            fb = crc[15] ^ b;
            crc = {crc[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
        end
        w = 7'h7F;
        for (int j = 0; j < len; j++)
            for (int k = 7; k >= 0; k--) begin
                b = ref_mem[j][k];
                fb = crc[15] ^ b;
                crc = {crc[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
                push(b ^ (wh & w[6]));
                w = {w[5:0], w[6] ^ w[3]};
            end
        for (int k = 15; k >= 0; k--) begin
            push(crc[k] ^ (wh & w[6]));
            w = {w[5:0], w[6] ^ w[3]};
        end
    endtask

    task automatic run_frame(input int pre, input int aw, input int len, input logic wh, input logic [63:0] adr);
        int bad_at;
        int stall_bad;
        build(pre, aw, len, wh, adr);
        @(negedge clk);
        pre_len = 3'(pre); addr_words = 2'(aw); pay_len = 7'(len);
        whiten_en = wh; addr_cfg = adr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R2 busy after start", longint'(busy), 1);
        // R10: disturb every configuration input during the frame
        pre_len = ~pre_len; addr_words = ~addr_words; pay_len = 7'((len + 9) % 65);
        whiten_en = ~wh; addr_cfg = ~adr;
        bad_at = -1;
        stall_bad = 0;
        for (int i = 0; i < n_exp; i++) begin
            if (tx_bit !== exp_bits[i] && bad_at < 0) bad_at = i;
            if (i == 2) begin
                start = 1'b1;   // R8
                @(negedge clk);
                start = 1'b0;
                if (tx_bit !== exp_bits[i] || busy !== 1'b1) stall_bad++;
            end
            if (i % 9 == 4) begin
                @(negedge clk); // R7 idle gap
                if (tx_bit !== exp_bits[i]) stall_bad++;
            end
            sym_en = 1'b1;
            @(negedge clk);
            sym_en = 1'b0;
        end
        chk(bad_at < 0, $sformatf("R2 R3 R4 R5 R6 R10 frame pre=%0d aw=%0d len=%0d wh=%0d first bad bit", pre, aw, len, wh),
            longint'(bad_at), -1);
        chk(stall_bad == 0, "R7 R8 bit held without strobe", longint'(stall_bad), 0);
        chk(done === 1'b1 && busy === 1'b0 && tx_bit === 1'b0, "R9 end of frame",
            longint'({done, busy, tx_bit}), 3'b100);
        @(negedge clk);
        chk(done === 1'b0, "R9 done one cycle", longint'(done), 0);
    endtask

    initial begin
        int lens [5] = '{0, 1, 3, 17, 64};
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && tx_bit === 1'b0, "R1 reset state",
            longint'({busy, done, tx_bit}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && tx_bit === 1'b0, "R1 idle after reset", longint'({busy, tx_bit}), 0);
        // strobe while idle must not start anything
        sym_en = 1'b1;
        @(negedge clk);
        sym_en = 1'b0;
        chk(busy === 1'b0, "R9 idle ignores strobe", longint'(busy), 0);
        for (int li = 0; li < 5; li++) begin
            fill(li); // R11 buffer content feeds the payload checks
            for (int pre = 0; pre < 8; pre++)
                for (int wh = 0; wh < 2; wh++)
                    run_frame(pre, (pre + li) % 4, lens[li], 1'(wh),
                              {16'hC3A5 ^ 16'(pre), 16'h5A0F ^ 16'(li), 16'h9E37, 16'h1B2D ^ 16'(wh)});
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule